// File: doc/BRIEF.md
# GPIO Pin Synchronizer and Event Detector

This block is the pin-side core of an eight-pin bidirectional general-purpose I/O port. Raw pad inputs are asynchronous to the block clock. Each bit passes through a two-flop synchronizer before any other logic uses it. The synchronized vector goes to the register side, which uses it as the data-in value.

In the opposite direction, the output value and the per-pin direction chosen by the register side go straight to the pads. The block adds no logic on that path.

From the synchronized input, every pin produces four indications:
- a level flag while the pin reads high;
- a level flag while the pin reads low;
- a one-clock pulse when the pin goes from 0 to 1;
- a one-clock pulse when the pin goes from 1 to 0.

An interrupt block placed after this one can mask and latch any of these indications.

Top module: `gpio_pin_core`

## Requirements
- R1: `pad_out` equals `drv_val` on every bit in the same cycle, whatever the value of `drv_en`.
- R2: `pad_oe` equals `drv_en` on every bit in the same cycle. A 1 means the pin drives and a 0 means the pin is an input.
- R3: `sync_in[i]` equals the value of `pad_in[i]` captured at the rising clock edge two edges earlier, using two flip-flop stages.
- R4: `lvl_hi[i]` is 1 exactly when `sync_in[i]` is 1, and `lvl_lo[i]` is 1 exactly when `sync_in[i]` is 0.
- R5: `rise[i]` is 1 for exactly the one cycle in which `sync_in[i]` first reads 1 after having read 0 in the previous cycle.
- R6: `fall[i]` is 1 for exactly the one cycle in which `sync_in[i]` first reads 0 after having read 1 in the previous cycle.
- R7: While `rst_n` is 0, the reset is asynchronous. During reset, `sync_in` is 0, `lvl_lo` is all ones, and `rise` and `fall` are 0. In the first cycle after release, `rise` and `fall` are also 0.
- R8: Pins are independent. Opposite transitions on different pins in the same cycle give `rise` on the pins that went up and `fall` on the pins that went down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Output value to pads |
| pad_oe | output | 8 | Per-pin drive enable to pads (1 = drive) |
| sync_in | output | 8 | Synchronized pad input for the data-in register |
| drv_val | input | 8 | Output value from the register side |
| drv_en | input | 8 | Direction from the register side (1 = output) |
| lvl_hi | output | 8 | Pin reads high |
| lvl_lo | output | 8 | Pin reads low |
| rise | output | 8 | One-cycle rising-edge pulse per pin |
| fall | output | 8 | One-cycle falling-edge pulse per pin |

## Verification
A wrong synchronizer stage shows up at `sync_in` and the level flags. They lag or lead the driven pad value by a cycle, and this is visible two edges after any change. A wrong history register shows up as a missing, doubled or stuck edge pulse in the cycle after the synchronized value changes. Stale state after reset shows up as a spurious pulse in the first cycle after release. Because a reference model compares every output on every clock, each of these faults is reported within one or two cycles of the stimulus that exposes it.

// File: rtl/gpio_pin_core.sv
`timescale 1ns/1ps
module gpio_pin_core #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] drv_val,
  input  logic [WIDTH-1:0] drv_en,
  output logic [WIDTH-1:0] lvl_hi,
  output logic [WIDTH-1:0] lvl_lo,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= '0;
    end else begin
      chain[0] <= pad_in;
      for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
      prev <= chain[LAST];
    end
  end

  assign sync_in = chain[LAST];
  assign pad_out = drv_val;
  assign pad_oe  = drv_en;
  assign lvl_hi  = sync_in;
  assign lvl_lo  = ~sync_in;
  assign rise    = sync_in & ~prev;
  assign fall    = ~sync_in & prev;

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise & $past(rise)) == '0);
  // R6
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall & $past(fall)) == '0);
  // R5
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |-> ((rise & lvl_hi) == rise));
  // R6
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall != '0) |-> ((fall & lvl_lo) == fall));
  // R7
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rise == '0 && fall == '0));

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      // R3
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (sync_in == $past(pad_in, 2)));
    end
  endgenerate
endmodule

// File: tb/gpio_pin_core_bench.sv
`timescale 1ns/1ps
module gpio_pin_core_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] pad_in = 0, drv_val = 0, drv_en = 0;
  logic [7:0] pad_out, pad_oe, sync_in, lvl_hi, lvl_lo, rise, fall;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] hist[$];
  bit just_released = 0;

  always #2.5 clk = ~clk;

  gpio_pin_core u_gpio_pin_core (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .sync_in(sync_in), .drv_val(drv_val), .drv_en(drv_en),
    .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .rise(rise), .fall(fall));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] s, p;
    string t;
    s = (hist.size() >= 2) ? hist[1] : 8'h00;
    p = (hist.size() >= 3) ? hist[2] : 8'h00;
    t = (!rst_n || just_released) ? " R7" : "";
    check("R1 pad_out", pad_out, drv_val);
    check("R2 pad_oe", pad_oe, drv_en);
    check({"R3 sync_in", t}, sync_in, s);
    check({"R4 lvl_hi", t}, lvl_hi, s);
    check({"R4 lvl_lo", t}, lvl_lo, ~s);
    check({"R5 R8 rise", t}, rise, s & ~p);
    check({"R6 R8 fall", t}, fall, ~s & p);
  endtask

  task automatic step(logic [7:0] v);
    @(negedge clk);
    compare_all();
    just_released = 0;
    pad_in  = v;
    drv_val = 8'($urandom);
    drv_en  = 8'($urandom);
    if (rst_n) begin
      hist.push_front(v);
      if (hist.size() > 3) void'(hist.pop_back());
    end
  endtask

  task automatic do_reset(logic [7:0] held);
    @(negedge clk);
    rst_n = 0;
    pad_in = held;
    hist.delete();
    #1;
    compare_all();
    for (int i = 0; i < 3; i++) step(held);
    @(negedge clk);
    compare_all();
    rst_n = 1;
    just_released = 1;
    hist.push_front(held);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(8'hFF);
    for (int i = 0; i < 6; i++) step(8'hFF);
    for (int i = 0; i < 16; i++) step(8'h01 << (i % 8));
    for (int i = 0; i < 12; i++) step((i % 2) ? 8'hAA : 8'h55);
    for (int i = 0; i < 8; i++) step(8'h00);
    for (int i = 0; i < 8; i++) step(8'hFF);
    for (int i = 0; i < 200; i++) step(8'($urandom));
    do_reset(8'h00);
    for (int i = 0; i < 10; i++) step(8'h0F);
    for (int i = 0; i < 10; i++) step(8'hF0);
    do_reset(8'h3C);
    for (int i = 0; i < 100; i++) step(8'($urandom));
    step(8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule